// File: doc/BRIEF.md
# UART Receive-Line Wake Detector

This block gives an asynchronous serial receiver a wake-up mode. Software arms it by writing the wake-enable bit. The register file decodes that bit from bit 1 of the baud control register and presents it here together with a write strobe. While the mode is armed, the normal character receiver is held off (`rcv_enable_o` low). The block then watches the raw receive line for the start of a break or wake character. Detection does not need the baud clock. A falling edge on the line is caught by a flop clocked by the line itself. The result is handed to the system-clock domain through a toggle and a two-flop synchronizer.

A falling edge while the mode is armed raises the receive interrupt flag. The flag stays set until the receive data register is read. The break ends on the first synchronized sample of a high line after the edge is registered. At that point the enable bit clears itself and normal reception resumes. While the core clock is stopped (`sleep_i` high), the interrupt output follows the edge capture directly, with no clock edge in between. With clocks running, the interrupt output is the registered flag.

The sender must make the wake character all zeros: 8 zero bits for plain serial links, or 12 for a LIN-style break. Any earlier rising edge ends the break too soon and corrupts the first character.

Top module: `uart_wake_detect`

## Requirements
- R1: A write (`cfg_we_i`=1) with `cfg_wake_i`=1 arms the mode on the next clock edge. While it is armed, `wake_en_o` reads 1 and `rcv_enable_o` reads 0.
- R2: While armed, a high-to-low transition on `rx_i` sets `rx_irq_o`. The flag is 0 after two rising clock edges following the transition and 1 after the third.
- R3: Transitions on `rx_i` while the mode is not armed leave `rx_irq_o` at 0 and the mode unarmed.
- R4: `data_rd_i` held for one clock clears `rx_irq_o` on that edge. Without a read the flag holds its value indefinitely.
- R5: After the falling edge, the mode stays armed while the line is low. The third rising clock edge after `rx_i` returns high clears `wake_en_o` and sets `rcv_enable_o`. The flag is left set.
- R6: `rx_quiet_o` is 1 from arming until the falling edge is registered. It is 0 from then on, including after the break ends.
- R7: A write with `cfg_wake_i`=0 while armed, before the line returns high, disarms the mode on that edge and restores `rcv_enable_o`. Any flag already set is left set.
- R8: With `sleep_i`=1 and the clock stopped, a falling edge on `rx_i` while armed drives `rx_irq_o` to 1 without any clock edge.
- R9: A low pulse shorter than one clock period while armed still counts as a wake event: the flag is set and the mode disarms.
- R10: After reset: `wake_en_o`=0, `rx_irq_o`=0, `rx_quiet_o`=0, `rcv_enable_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; may be stopped during sleep |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_i | input | 1 | High while the core clocks are stopped |
| rx_i | input | 1 | Raw receive line, idle high |
| cfg_we_i | input | 1 | Write strobe for the baud control register |
| cfg_wake_i | input | 1 | Written value of the wake-enable bit |
| data_rd_i | input | 1 | Strobe for a read of the receive data register |
| wake_en_o | output | 1 | Read-back of the wake-enable bit |
| rx_quiet_o | output | 1 | Receiver-idle status while armed and waiting |
| rx_irq_o | output | 1 | Receive interrupt flag |
| rcv_enable_o | output | 1 | Permits the normal character receiver |

## Verification
The bench drives low pulses shorter than one clock. A design that sampled the line only through the synchronizer would miss these and leave the mode armed. It also stops the clock and checks the interrupt pin during the stall. A design that raised the interrupt only through registers would stay silent there. Breaks of 8 and 12 bit times, hand-disarming mid-break and edges while unarmed are checked as well. These catch three faults: a flag that drops when the mode disarms, a break ended while the line is still low, and edges latched while the mode is off.

// File: rtl/uwk_pkg.sv
`timescale 1ns/1ps
package uwk_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_ARMED = 2'd1,
    PH_BREAK = 2'd2
  } phase_e;
endpackage

// File: rtl/uwk_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer with a parameterized reset value.
module uwk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_d = d_i;
    end else begin : g_many
      always_comb sr_d = {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uwk_edge_catch.sv
`timescale 1ns/1ps
// Flop clocked by the falling receive line. It toggles once per wake
// event and needs no system clock, so it works while the core sleeps.
module uwk_edge_catch (
  input  logic rx_i,
  input  logic rst_n,
  input  logic arm_i,
  input  logic ack_i,
  output logic tog_o,
  output logic pend_o
);
  logic tog_q;
  logic tog_d;

  assign pend_o = tog_q ^ ack_i;

  always_comb tog_d = ~tog_q;

  // Toggle only while armed and no earlier event is unacknowledged,
  // so that a second edge can never cancel the first.
  always_ff @(negedge rx_i or negedge rst_n) begin
    if (!rst_n)                tog_q <= 1'b0;
    else if (arm_i && !pend_o) tog_q <= tog_d;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/uwk_ctrl.sv
`timescale 1ns/1ps
// Phase machine and interrupt flag in the system clock domain.
module uwk_ctrl
  import uwk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic cfg_we_i,
  input  logic cfg_wake_i,
  input  logic data_rd_i,
  input  logic rx_s_i,
  input  logic tog_s_i,
  input  logic pend_raw_i,
  output logic ack_o,
  output logic armed_o,
  output logic wake_en_o,
  output logic rx_quiet_o,
  output logic rx_irq_o,
  output logic rcv_enable_o
);
  phase_e phase_q, phase_d;
  logic   flag_q, flag_d;
  logic   ack_q, ack_d;
  logic   wake_evt, sw_set, sw_clear;

  always_comb begin
    sw_set   = cfg_we_i && cfg_wake_i;
    sw_clear = cfg_we_i && !cfg_wake_i;
    wake_evt = (phase_q == PH_ARMED) && (tog_s_i != ack_q);
    phase_d  = phase_q;
    flag_d   = flag_q;
    ack_d    = ack_q;
    if (data_rd_i) flag_d = 1'b0;
    case (phase_q)
      PH_OFF: begin
        ack_d = tog_s_i;
        if (sw_set) phase_d = PH_ARMED;
      end
      PH_ARMED: begin
        if (wake_evt) begin
          flag_d  = 1'b1;
          ack_d   = tog_s_i;
          phase_d = PH_BREAK;
        end
        if (sw_clear) phase_d = PH_OFF;
      end
      PH_BREAK: begin
        if (sw_clear || rx_s_i) phase_d = PH_OFF;
      end
      default: phase_d = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      flag_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      flag_q  <= flag_d;
      ack_q   <= ack_d;
    end
  end

  assign ack_o        = ack_q;
  assign armed_o      = (phase_q == PH_ARMED);
  assign wake_en_o    = (phase_q != PH_OFF);
  assign rx_quiet_o   = (phase_q == PH_ARMED);
  assign rcv_enable_o = (phase_q == PH_OFF);
  assign rx_irq_o     = flag_q | (sleep_i & armed_o & pend_raw_i);

  // R2: the flag only rises out of the armed phase
  p_flag_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(phase_q) == PH_ARMED);

  // R2: entering the break phase always comes with a set flag
  p_break_flagged_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BREAK && $past(phase_q) == PH_ARMED) |-> flag_q);

  // R4: a read with no coinciding event clears the flag
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_i && !wake_evt) |=> !flag_q);

  // R5: a low synchronized line keeps the break going
  p_end_needs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BREAK && !sw_clear && !rx_s_i) |=> phase_q == PH_BREAK);

  // R7: disarming by hand keeps a pending flag
  p_manual_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && phase_q != PH_OFF && flag_q && !data_rd_i)
      |=> (phase_q == PH_OFF && flag_q));
endmodule

// File: rtl/uart_wake_detect.sv
`timescale 1ns/1ps
module uart_wake_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic rx_i,
  input  logic cfg_we_i,
  input  logic cfg_wake_i,
  input  logic data_rd_i,
  output logic wake_en_o,
  output logic rx_quiet_o,
  output logic rx_irq_o,
  output logic rcv_enable_o
);
  logic rst_sync_n;
  logic rx_s, tog_raw, tog_s, pend_raw, ack, armed;

  uwk_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sync_n));

  uwk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(rx_i), .q_o(rx_s));

  uwk_edge_catch u_edge (
    .rx_i(rx_i), .rst_n(rst_n), .arm_i(armed), .ack_i(ack),
    .tog_o(tog_raw), .pend_o(pend_raw));

  uwk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(tog_raw), .q_o(tog_s));

  uwk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .sleep_i(sleep_i),
    .cfg_we_i(cfg_we_i), .cfg_wake_i(cfg_wake_i), .data_rd_i(data_rd_i),
    .rx_s_i(rx_s), .tog_s_i(tog_s), .pend_raw_i(pend_raw),
    .ack_o(ack), .armed_o(armed), .wake_en_o(wake_en_o),
    .rx_quiet_o(rx_quiet_o), .rx_irq_o(rx_irq_o),
    .rcv_enable_o(rcv_enable_o));
endmodule

// File: tb/uart_wake_detect_tb.sv
`timescale 1ns/1ps
module uart_wake_detect_tb;
  localparam int BIT_CLKS = 8;

  logic clk = 1'b0, clk_run = 1'b1;
  logic rst_n, sleep_i, rx_i, cfg_we_i, cfg_wake_i, data_rd_i;
  logic wake_en_o, rx_quiet_o, rx_irq_o, rcv_enable_o;
  int total = 0, fails = 0;
  bit done = 1'b0;

  uart_wake_detect u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .rx_i(rx_i),
    .cfg_we_i(cfg_we_i), .cfg_wake_i(cfg_wake_i), .data_rd_i(data_rd_i),
    .wake_en_o(wake_en_o), .rx_quiet_o(rx_quiet_o), .rx_irq_o(rx_irq_o),
    .rcv_enable_o(rcv_enable_o));

  initial forever begin
    #10;
    if (clk_run) clk = ~clk;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic bit exp_flag(input bit armed, input bit pulsed);
    return armed & pulsed;
  endfunction

  function automatic int break_len(input int kind);
    return (kind == 0) ? 8 * BIT_CLKS : 12 * BIT_CLKS;
  endfunction

  task automatic arm();
    cfg_we_i = 1'b1; cfg_wake_i = 1'b1;
    step(1);
    cfg_we_i = 1'b0; cfg_wake_i = 1'b0;
  endtask

  task automatic read_flag();
    data_rd_i = 1'b1;
    step(1);
    data_rd_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5A17);
    rst_n = 1'b0; sleep_i = 1'b0; rx_i = 1'b1;
    cfg_we_i = 1'b0; cfg_wake_i = 1'b0; data_rd_i = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk("R10 wake_en", wake_en_o, 1'b0);
    chk("R10 irq", rx_irq_o, 1'b0);
    chk("R10 quiet", rx_quiet_o, 1'b0);
    chk("R10 rcv_enable", rcv_enable_o, 1'b1);

    // Directed: full break with exact latency
    arm();
    chk("R1 wake_en", wake_en_o, 1'b1);
    chk("R1 rcv_enable", rcv_enable_o, 1'b0);
    chk("R6 quiet armed", rx_quiet_o, 1'b1);
    rx_i = 1'b0;
    step(2);
    chk("R2 flag not yet", rx_irq_o, 1'b0);
    step(1);
    chk("R2 flag set", rx_irq_o, 1'b1);
    chk("R6 quiet after edge", rx_quiet_o, 1'b0);
    step(8 * BIT_CLKS);
    chk("R5 still armed while low", wake_en_o, 1'b1);
    chk("R5 receiver held", rcv_enable_o, 1'b0);
    rx_i = 1'b1;
    step(2);
    chk("R5 not ended yet", wake_en_o, 1'b1);
    step(1);
    chk("R5 auto clear", wake_en_o, 1'b0);
    chk("R5 receiver back", rcv_enable_o, 1'b1);
    chk("R5 flag kept", rx_irq_o, 1'b1);
    chk("R6 quiet after break", rx_quiet_o, 1'b0);
    step(20);
    chk("R4 flag holds", rx_irq_o, 1'b1);
    read_flag();
    chk("R4 read clears", rx_irq_o, 1'b0);

    // Directed: manual disarm mid-break
    arm();
    rx_i = 1'b0;
    step(5);
    cfg_we_i = 1'b1; cfg_wake_i = 1'b0;
    step(1);
    cfg_we_i = 1'b0;
    chk("R7 disarmed", wake_en_o, 1'b0);
    chk("R7 receiver back", rcv_enable_o, 1'b1);
    chk("R7 flag kept", rx_irq_o, 1'b1);
    rx_i = 1'b1;
    step(4);
    read_flag();

    // Directed: edges while unarmed
    rx_i = 1'b0; step(3); rx_i = 1'b1; step(5);
    chk("R3 no flag unarmed", rx_irq_o, 1'b0);
    chk("R3 stays unarmed", wake_en_o, 1'b0);

    // Directed: edge while the clock is stopped
    arm();
    clk_run = 1'b0;
    sleep_i = 1'b1;
    #30;
    chk("R8 irq low before edge", rx_irq_o, 1'b0);
    rx_i = 1'b0;
    #1;
    chk("R8 async irq", rx_irq_o, 1'b1);
    #40;
    rx_i = 1'b1;
    #20;
    clk_run = 1'b1;
    step(6);
    sleep_i = 1'b0;
    #1;
    chk("R8 flag after wake", rx_irq_o, 1'b1);
    chk("R8 disarmed after wake", wake_en_o, 1'b0);
    read_flag();

    // Directed: sub-clock glitch
    arm();
    #3 rx_i = 1'b0;
    #4 rx_i = 1'b1;
    step(6);
    chk("R9 glitch flag", rx_irq_o, 1'b1);
    chk("R9 glitch disarms", wake_en_o, 1'b0);
    read_flag();

    // Random mix
    for (int it = 0; it < 60; it++) begin
      int kind;
      int gap;
      bit armed;
      kind  = $urandom_range(0, 3);
      armed = ($urandom_range(0, 3) != 0);
      gap   = $urandom_range(1, 10);
      if (armed) begin
        arm();
        chk("R1 random armed", rcv_enable_o, 1'b0);
      end
      step(gap);
      if (armed) chk("R6 random quiet", rx_quiet_o, 1'b1);
      if (kind == 2) begin
        #3 rx_i = 1'b0;
        #4 rx_i = 1'b1;
      end else if (kind == 3) begin
        rx_i = 1'b0;
        step($urandom_range(1, 3));
        rx_i = 1'b1;
      end else begin
        rx_i = 1'b0;
        step(break_len(kind));
        if (armed) chk("R5 random held", wake_en_o, 1'b1);
        rx_i = 1'b1;
      end
      step(6);
      chk("R2 random flag", rx_irq_o, exp_flag(armed, 1'b1));
      chk("R5 random disarmed", wake_en_o, 1'b0);
      chk("R5 random receiver", rcv_enable_o, 1'b1);
      read_flag();
      chk("R4 random read", rx_irq_o, 1'b0);
    end

    finish_run();
  end
endmodule